// File: doc/BRIEF.md
# One-Time Security Region Lock Controller

This block is the command front end for a small security region that sits beside the main array of a NOR-flash-style memory. It watches bus write cycles (address, data, write strobe) and steps through a short command dialogue. One code moves reads and program/erase requests from the main array onto the security region. A two-code sequence moves them back. A protect dialogue, open only while a dedicated protect-enable level has been held for long enough, sets a lock bit for the region. Once set, that bit can never be cleared by any command.

While the protect dialogue is open, a read from a qualified region address returns the lock status instead of stored data. While the region is locked, every program or erase request aimed at it is refused with a one-cycle reject pulse and leaves its contents unchanged. The main array stays writable. The storage itself is modelled as registers. Program clears bits (bitwise AND with the written data) and erase sets one word to all ones. Each accepted request answers with a one-cycle acknowledge.

A qualified address is any address with bit 6 = 0, bit 1 = 1 and bit 0 = 0. The other address bits are free. All command codes are 8-bit hexadecimal values.

Top module: `otp_region_guard`

## Requirements
- R1: After power-on reset every main-array word and every region word reads FFh, the lock is clear, reads target the main array and no protect dialogue is open.
- R2: With the protect dialogue armed (code 60h written to any address), writing 40h to a qualified address while the region is selected sets the lock and moves to the verify step.
- R3: In the armed or verify step, with the region selected, a read from a qualified address returns 01h if locked and 00h if unlocked. Any other read returns stored data. Read data appears one clock after the read strobe.
- R4: The lock, once set, stays set for every later command write of any data value to any address. Only power-on reset clears it.
- R5: While locked, a program or erase request to the region raises the reject output for one cycle, raises no acknowledge, and leaves every region word unchanged.
- R6: Code 60h arms only if the protect-enable input has been high on at least HOLD_CYCLES consecutive clock edges before the write. Otherwise the write is ignored. Dropping protect-enable returns an armed or verify dialogue to read mode.
- R7: In the armed step, any write other than 40h at a qualified address with the region selected aborts to read mode without changing the lock. A 40h written without arming first has no effect.
- R8: Writing F0h in the verify step returns to read mode. Qualified reads then return stored data, and the region stays selected.
- R9: Writing 88h in read mode selects the region. Writing 90h then 00h deselects it. 90h followed by any other value leaves it selected.
- R10: A program request ANDs its data into the addressed word. An erase request sets the word to FFh. Either one is acknowledged one cycle later. Main-array requests are always accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; the only reset of the lock |
| prot_en_i | input | 1 | Protect-enable level that must be held before arming |
| cmd_we_i | input | 1 | Command write strobe, one cycle per write |
| cmd_addr_i | input | ADDR_W | Command write address |
| cmd_data_i | input | 8 | Command write data |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Read data, registered |
| pe_req_i | input | 1 | Program/erase request strobe |
| pe_erase_i | input | 1 | 1 = erase word, 0 = program word |
| pe_addr_i | input | ADDR_W | Program/erase word address |
| pe_data_i | input | 8 | Program data |
| pe_ack_o | output | 1 | Request accepted (one-cycle pulse) |
| pe_reject_o | output | 1 | Request refused, region locked (one-cycle pulse) |

## Verification
The hardest condition to reach is proving that no command can clear the lock. The lock is a one-way bit, so every unlocked-path check has to come before it is set. The bench therefore runs all the abort cases first: each of the seven wrong low-bit address patterns, wrong data, an unselected region and a missing arm. After each one it re-arms and reads back status 00h. Only then does it set the lock. It then sweeps all 256 data codes through both the armed step and plain read mode, and afterwards reads status 01h and confirms that region requests are still rejected. The arming threshold is hit exactly by holding protect-enable for HOLD_CYCLES-1 and then HOLD_CYCLES edges.

// File: rtl/otp_guard_pkg.sv
package otp_guard_pkg;

    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] CODE_ARM    = 8'h60;
    localparam logic [DATA_W-1:0] CODE_LOCK   = 8'h40;
    localparam logic [DATA_W-1:0] CODE_RESET  = 8'hF0;
    localparam logic [DATA_W-1:0] CODE_ENTER  = 8'h88;
    localparam logic [DATA_W-1:0] CODE_EXIT_A = 8'h90;
    localparam logic [DATA_W-1:0] CODE_EXIT_B = 8'h00;

    // Qualified address: bit6 = 0, bit1 = 1, bit0 = 0
    localparam logic [31:0] QUAL_MASK = 32'h0000_0043;
    localparam logic [31:0] QUAL_VAL  = 32'h0000_0002;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_VERIFY = 2'd2,
        ST_EXIT1  = 2'd3
    } cmd_state_e;

    typedef struct packed {
        cmd_state_e state;
        logic       region;
        logic       lock;
    } fsm_regs_t;

    function automatic logic is_qual(logic [31:0] a);
        return (a & QUAL_MASK) == QUAL_VAL;
    endfunction

endpackage

// File: rtl/otp_hold_timer.sv
module otp_hold_timer #(
    parameter int HOLD_CYCLES = 200
) (
    input  logic clk,
    input  logic por_n,
    input  logic level_i,
    output logic ok_o
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HOLD_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t q, d;

    always_comb begin
        d = q;
        if (!level_i) begin
            d.cnt = '0;
        end else if (q.cnt != CNT_MAX) begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ok_o = level_i && (q.cnt == CNT_MAX);

    AST_HOLD_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!por_n)
        ok_o |-> $past(level_i)); // R6

endmodule

// File: rtl/otp_cmd_fsm.sv
module otp_cmd_fsm
    import otp_guard_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                hold_ok_i,
    input  logic                we_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   data_i,
    output logic                region_o,
    output logic                status_en_o,
    output logic                lock_o
);
    fsm_regs_t q, d;
    logic      qual;

    assign qual = is_qual(32'(addr_i));

    always_comb begin
        d = q;
        if ((q.state == ST_ARMED || q.state == ST_VERIFY) && !hold_ok_i) begin
            d.state = ST_IDLE;
        end else if (we_i) begin
            case (q.state)
                ST_IDLE: begin
                    if (data_i == CODE_ENTER) begin
                        d.region = 1'b1;
                    end else if (data_i == CODE_EXIT_A) begin
                        d.state = ST_EXIT1;
                    end else if (data_i == CODE_ARM && hold_ok_i) begin
                        d.state = ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (data_i == CODE_LOCK && qual && q.region) begin
                        d.lock  = 1'b1;
                        d.state = ST_VERIFY;
                    end else begin
                        d.state = ST_IDLE;
                    end
                end
                ST_VERIFY: begin
                    // CODE_RESET ends verify; any other value aborts the same way
                    d.state = ST_IDLE;
                end
                ST_EXIT1: begin
                    if (data_i == CODE_EXIT_B) begin
                        d.region = 1'b0;
                    end
                    d.state = ST_IDLE;
                end
                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q <= '{state: ST_IDLE, region: 1'b0, lock: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign region_o    = q.region;
    assign status_en_o = (q.state == ST_ARMED) || (q.state == ST_VERIFY);
    assign lock_o      = q.lock;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        q.lock |=> q.lock); // R4

    AST_LOCK_FROM_ARMED: assert property (@(posedge clk) disable iff (!por_n)
        $rose(q.lock) |-> $past(q.state == ST_ARMED && we_i)); // R2

    AST_ARM_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (q.state == ST_ARMED && $past(q.state == ST_IDLE)) |-> $past(hold_ok_i)); // R6

    AST_DESELECT_VIA_EXIT: assert property (@(posedge clk) disable iff (!por_n)
        $fell(q.region) |-> $past(q.state == ST_EXIT1)); // R9

endmodule

// File: rtl/otp_store.sv
module otp_store
    import otp_guard_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int ARRAY_WORDS  = 32,
    parameter int REGION_WORDS = 16
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                region_i,
    input  logic                lock_i,
    input  logic                status_en_i,
    input  logic                rd_en_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    output logic [DATA_W-1:0]   rd_data_o,
    input  logic                pe_req_i,
    input  logic                pe_erase_i,
    input  logic [ADDR_W-1:0]   pe_addr_i,
    input  logic [DATA_W-1:0]   pe_data_i,
    output logic                pe_ack_o,
    output logic                pe_reject_o
);
    localparam int AIDX_W = (ARRAY_WORDS  > 1) ? $clog2(ARRAY_WORDS)  : 1;
    localparam int RIDX_W = (REGION_WORDS > 1) ? $clog2(REGION_WORDS) : 1;

    typedef struct packed {
        logic [ARRAY_WORDS-1:0][DATA_W-1:0]  arr;
        logic [REGION_WORDS-1:0][DATA_W-1:0] rgn;
        logic [DATA_W-1:0]                   rd;
        logic                                ack;
        logic                                rej;
    } store_t;

    store_t q, d;

    logic [AIDX_W-1:0] pe_ai, rd_ai;
    logic [RIDX_W-1:0] pe_ri, rd_ri;
    logic              rd_qual;

    assign pe_ai   = AIDX_W'(32'(pe_addr_i) % ARRAY_WORDS);
    assign rd_ai   = AIDX_W'(32'(rd_addr_i) % ARRAY_WORDS);
    assign pe_ri   = RIDX_W'(32'(pe_addr_i) % REGION_WORDS);
    assign rd_ri   = RIDX_W'(32'(rd_addr_i) % REGION_WORDS);
    assign rd_qual = is_qual(32'(rd_addr_i));

    always_comb begin
        d     = q;
        d.ack = 1'b0;
        d.rej = 1'b0;
        if (pe_req_i) begin
            if (region_i) begin
                if (lock_i) begin
                    d.rej = 1'b1;
                end else begin
                    d.ack = 1'b1;
                    d.rgn[pe_ri] = pe_erase_i ? {DATA_W{1'b1}}
                                              : (q.rgn[pe_ri] & pe_data_i);
                end
            end else begin
                d.ack = 1'b1;
                d.arr[pe_ai] = pe_erase_i ? {DATA_W{1'b1}}
                                          : (q.arr[pe_ai] & pe_data_i);
            end
        end
        if (rd_en_i) begin
            if (status_en_i && region_i && rd_qual) begin
                d.rd = {{(DATA_W-1){1'b0}}, lock_i};
            end else if (region_i) begin
                d.rd = q.rgn[rd_ri];
            end else begin
                d.rd = q.arr[rd_ai];
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q.arr <= '1;
            q.rgn <= '1;
            q.rd  <= '0;
            q.ack <= 1'b0;
            q.rej <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rd_data_o   = q.rd;
    assign pe_ack_o    = q.ack;
    assign pe_reject_o = q.rej;

    AST_ACK_XOR_REJECT: assert property (@(posedge clk) disable iff (!por_n)
        !(pe_ack_o && pe_reject_o)); // R5

    AST_LOCKED_REJECTS: assert property (@(posedge clk) disable iff (!por_n)
        (pe_req_i && region_i && lock_i) |=> (pe_reject_o && !pe_ack_o)); // R5

    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
        lock_i |=> $stable(q.rgn)); // R5

    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!por_n)
        pe_ack_o |-> $past(pe_req_i)); // R10

endmodule

// File: rtl/otp_region_guard.sv
module otp_region_guard
    import otp_guard_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int ARRAY_WORDS  = 32,
    parameter int REGION_WORDS = 16,
    parameter int HOLD_CYCLES  = 200
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                prot_en_i,
    input  logic                cmd_we_i,
    input  logic [ADDR_W-1:0]   cmd_addr_i,
    input  logic [7:0]          cmd_data_i,
    input  logic                rd_en_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    output logic [7:0]          rd_data_o,
    input  logic                pe_req_i,
    input  logic                pe_erase_i,
    input  logic [ADDR_W-1:0]   pe_addr_i,
    input  logic [7:0]          pe_data_i,
    output logic                pe_ack_o,
    output logic                pe_reject_o
);
    logic hold_ok;
    logic region;
    logic status_en;
    logic lock;

    otp_hold_timer #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_hold (
        .clk     (clk),
        .por_n   (por_n),
        .level_i (prot_en_i),
        .ok_o    (hold_ok)
    );

    otp_cmd_fsm #(
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk         (clk),
        .por_n       (por_n),
        .hold_ok_i   (hold_ok),
        .we_i        (cmd_we_i),
        .addr_i      (cmd_addr_i),
        .data_i      (cmd_data_i),
        .region_o    (region),
        .status_en_o (status_en),
        .lock_o      (lock)
    );

    otp_store #(
        .ADDR_W       (ADDR_W),
        .ARRAY_WORDS  (ARRAY_WORDS),
        .REGION_WORDS (REGION_WORDS)
    ) u_store (
        .clk         (clk),
        .por_n       (por_n),
        .region_i    (region),
        .lock_i      (lock),
        .status_en_i (status_en),
        .rd_en_i     (rd_en_i),
        .rd_addr_i   (rd_addr_i),
        .rd_data_o   (rd_data_o),
        .pe_req_i    (pe_req_i),
        .pe_erase_i  (pe_erase_i),
        .pe_addr_i   (pe_addr_i),
        .pe_data_i   (pe_data_i),
        .pe_ack_o    (pe_ack_o),
        .pe_reject_o (pe_reject_o)
    );

endmodule

// File: tb/otp_region_guard_tb.sv
`timescale 1ns/1ps
module otp_region_guard_tb;
    localparam int AW   = 32;
    localparam int RW   = 16;
    localparam int HOLD = 200;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       prot_en = 1'b0;
    logic       cmd_we = 1'b0;
    logic [7:0] cmd_addr = '0;
    logic [7:0] cmd_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       pe_req = 1'b0;
    logic       pe_erase = 1'b0;
    logic [7:0] pe_addr = '0;
    logic [7:0] pe_data = '0;
    logic       pe_ack;
    logic       pe_reject;

    int checks = 0;
    int errors = 0;
    logic [7:0] arr_m [AW];
    logic [7:0] rgn_m [RW];

    always #2.5 clk = ~clk;

    otp_region_guard #(
        .ADDR_W(8), .ARRAY_WORDS(AW), .REGION_WORDS(RW), .HOLD_CYCLES(HOLD)
    ) u_dut (
        .clk(clk), .por_n(por_n), .prot_en_i(prot_en),
        .cmd_we_i(cmd_we), .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .pe_req_i(pe_req), .pe_erase_i(pe_erase), .pe_addr_i(pe_addr),
        .pe_data_i(pe_data), .pe_ack_o(pe_ack), .pe_reject_o(pe_reject)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] dd);
        cmd_we = 1'b1; cmd_addr = a; cmd_data = dd;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic rchk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        chk(tag, {24'h0, rd_data}, {24'h0, exp});
    endtask

    task automatic pe(input string tag, input logic er, input logic [7:0] a,
                      input logic [7:0] dd, input logic exp_ack, input logic exp_rej);
        pe_req = 1'b1; pe_erase = er; pe_addr = a; pe_data = dd;
        @(negedge clk);
        pe_req = 1'b0;
        chk(tag, {30'h0, pe_ack, pe_reject}, {30'h0, exp_ack, exp_rej});
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < AW; i++) arr_m[i] = 8'hFF;
        for (int i = 0; i < RW; i++) rgn_m[i] = 8'hFF;
        repeat (5) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);

        // R1: erased state after reset, main array selected
        for (int a = 0; a < AW; a++) rchk("R1 array reset", 8'(a), 8'hFF);
        chk("R1 no ack/reject", {30'h0, pe_ack, pe_reject}, 32'h0);
        wr(8'h00, 8'h88);
        for (int i = 0; i < RW; i++) rchk("R1 region reset", 8'(i), 8'hFF);
        wr(8'h00, 8'h90); wr(8'h00, 8'h00);

        // R10: program ANDs, erase sets FFh, ack one cycle later
        for (int a = 0; a < AW; a++) begin
            pe("R10 program ack", 1'b0, 8'(a), 8'(a * 37 + 11), 1'b1, 1'b0);
            arr_m[a] = arr_m[a] & 8'(a * 37 + 11);
        end
        for (int a = 0; a < AW; a++) begin
            pe("R10 program ack 2", 1'b0, 8'(a), 8'hF3 ^ 8'(a), 1'b1, 1'b0);
            arr_m[a] = arr_m[a] & (8'hF3 ^ 8'(a));
        end
        pe("R10 erase ack", 1'b1, 8'd5, 8'h00, 1'b1, 1'b0);  arr_m[5]  = 8'hFF;
        pe("R10 erase ack", 1'b1, 8'd17, 8'h00, 1'b1, 1'b0); arr_m[17] = 8'hFF;
        for (int a = 0; a < AW; a++) rchk("R10 array data", 8'(a), arr_m[a]);

        // R9: region select routes requests and reads; exit needs 90h then 00h
        wr(8'h00, 8'h88);
        for (int i = 0; i < RW; i++) begin
            pe("R9 region program", 1'b0, 8'(i), ~8'(i), 1'b1, 1'b0);
            rgn_m[i] = rgn_m[i] & ~8'(i);
        end
        for (int i = 0; i < RW; i++) rchk("R9 region data", 8'(i), rgn_m[i]);
        wr(8'h00, 8'h90); wr(8'h00, 8'h55);
        rchk("R9 broken exit keeps region", 8'd3, rgn_m[3]);
        wr(8'h00, 8'h90); wr(8'h00, 8'h00);
        rchk("R9 exit returns array", 8'd3, arr_m[3]);
        rchk("R9 exit returns array", 8'd12, arr_m[12]);

        // R6: arming needs HOLD consecutive edges of protect-enable
        wr(8'h00, 8'h88);
        wr(8'h00, 8'h60);
        rchk("R6 arm ignored without enable", 8'h02, rgn_m[2]);
        prot_en = 1'b1;
        repeat (HOLD - 1) @(negedge clk);
        wr(8'h00, 8'h60);
        rchk("R6 arm ignored at HOLD-1", 8'h02, rgn_m[2]);
        wr(8'h00, 8'h60);
        rchk("R3 unlocked status 00h", 8'h02, 8'h00);
        prot_en = 1'b0;
        @(negedge clk);
        rchk("R6 drop aborts armed", 8'h02, rgn_m[2]);
        prot_en = 1'b1;
        repeat (HOLD) @(negedge clk);

        // R7: wrong low-bit patterns (bit6,bit1,bit0) abort without locking
        for (int c = 0; c < 8; c++) begin
            if (c != 2) begin
                wr(8'h00, 8'h60);
                wr(8'((c[2] << 6) | (c[1] << 1) | c[0]) | 8'h10, 8'h40);
                rchk("R7 bad address aborts", 8'h02, rgn_m[2]);
                wr(8'h00, 8'h60);
                rchk("R7 lock still clear", 8'h02, 8'h00);
                wr(8'h00, 8'hF0);
            end
        end
        wr(8'h00, 8'h60); wr(8'h02, 8'h41);
        rchk("R7 bad data aborts", 8'h02, rgn_m[2]);
        wr(8'h00, 8'h60);
        rchk("R7 lock still clear", 8'h02, 8'h00);
        wr(8'h00, 8'hF0);
        wr(8'h02, 8'h40);
        wr(8'h00, 8'h60);
        rchk("R7 unarmed 40h ignored", 8'h02, 8'h00);
        wr(8'h00, 8'hF0);
        wr(8'h00, 8'h90); wr(8'h00, 8'h00);
        wr(8'h00, 8'h60); wr(8'h02, 8'h40);
        wr(8'h00, 8'h88); wr(8'h00, 8'h60);
        rchk("R7 unselected region no lock", 8'h02, 8'h00);
        wr(8'h00, 8'hF0);

        // R2/R3: set lock, read status at qualified addresses only
        wr(8'h00, 8'h60); wr(8'h02, 8'h40);
        rchk("R2 lock status 01h", 8'h02, 8'h01);
        rchk("R3 status at 86h", 8'h86, 8'h01);
        rchk("R3 data at 03h", 8'h03, rgn_m[3]);
        rchk("R3 bit6 set gives data", 8'h42, rgn_m[2]);

        // R8: F0h ends verify, region stays selected
        wr(8'h00, 8'hF0);
        rchk("R8 reset gives data", 8'h02, rgn_m[2]);
        rchk("R8 region still selected", 8'h05, rgn_m[5]);

        // R5: locked region refuses program and erase
        for (int i = 0; i < RW; i++) pe("R5 program rejected", 1'b0, 8'(i), 8'h00, 1'b0, 1'b1);
        pe("R5 erase rejected", 1'b1, 8'd4, 8'h00, 1'b0, 1'b1);
        for (int i = 0; i < RW; i++) rchk("R5 region unchanged", 8'(i), rgn_m[i]);
        wr(8'h00, 8'h90); wr(8'h00, 8'h00);
        pe("R5 array still writable", 1'b0, 8'd2, 8'h0F, 1'b1, 1'b0);
        arr_m[2] = arr_m[2] & 8'h0F;
        rchk("R5 array data", 8'd2, arr_m[2]);

        // R4: no data code clears the lock, armed or not
        wr(8'h00, 8'h88);
        for (int dv = 0; dv < 256; dv++) begin
            wr(8'h00, 8'h60);
            wr(8'h02, 8'(dv));
            wr(8'h00, 8'hF0);
            wr(8'h02, 8'(dv));
        end
        wr(8'h00, 8'hF0);
        wr(8'h00, 8'h60);
        rchk("R4 lock survives sweep", 8'h02, 8'h01);
        wr(8'h00, 8'hF0);
        pe("R4 region still rejected", 1'b0, 8'd7, 8'h00, 1'b0, 1'b1);
        rchk("R4 region word kept", 8'd7, rgn_m[7]);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule